// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

The router takes interrupt events from up to 64 device request lines and sends them to as many as four processors. All processors share one raw request vector. Each processor has its own enable mask, and its pending vector is that mask ANDed with the raw vector. Each processor has one level-sensitive interrupt output. That output is high whenever any bit of its pending vector is set, so a mask write or a request change raises or withdraws the interrupt on the next clock edge.

Devices report events as a line number plus an assert/deassert flag. Software uses a 64-bit register port to program the masks and to read the masks, the pending vectors and the raw requests. Registers sit on 64-byte strides. Only full 8-byte accesses are accepted. Illegal accesses produce a one-cycle error pulse, and so does a deassert of a line that is already clear.

Top module: `irq_router`

## Requirements
- R1: While `rst_n` is low, every mask and the raw request vector are cleared, so `irq_o`, `raw_req_o`, `dev_spurious` and `reg_err` are all zero.
- R2: Reading register index 4+n returns processor n's pending vector, which is mask n AND the raw request vector.
- R3: A legal write to register index n (n below the processor count) replaces mask n with `reg_wdata` from the next edge on, and reading index n returns it.
- R4: `irq_o[n]` is high exactly when processor n's pending vector is non-zero. It rises after a mask write that enables an active line and falls after a mask write that removes the last pending bit.
- R5: An assert event (`dev_valid` with `dev_assert`=1) sets raw bit `dev_line` at the next edge and raises the interrupt of every processor whose mask has that bit.
- R6: A deassert event clears raw bit `dev_line` and withdraws it from every processor that had it pending. If the bit is already clear, nothing changes and `dev_spurious` is high for one cycle.
- R7: The register index is `reg_addr[11:6]`, and the low six address bits are ignored. The raw request vector is read at index 8.
- R8: A write to a pending or raw index (4 to 7, or 8) is ignored, and `reg_err` pulses in the following cycle. A read or write of an unmapped index does the same, and a read of an unmapped index returns zero.
- R9: Any access with `reg_size` other than 8 bytes is ignored and pulses `reg_err`. A read of that kind returns zero.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. `raw_req_o` always shows the raw request vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| reg_err | output | 1 | One-cycle pulse after an illegal access |
| dev_valid | input | 1 | Device event strobe |
| dev_assert | input | 1 | 1 asserts, 0 deasserts the line |
| dev_line | input | 6 | Device request line number |
| dev_spurious | output | 1 | One-cycle pulse after a deassert of a clear line |
| raw_req_o | output | 64 | Active raw request lines |
| irq_o | output | 4 | Interrupt level per processor |

## Verification
The routing is exercised in several ways:
- a line that one processor enables and another does not;
- a line enabled by two processors at once;
- the top line (63), enabled only by the last processor;
- a mask that covers every line.

Together these separate a per-processor AND from a shared one, and they expose swapped mask or pending indices. Withdrawals are driven both by a mask rewrite and by a deassert event, so the two clearing paths are told apart. A deassert of a clear line is checked against a genuine deassert to confirm that only the first one flags. Read-only writes, short-size accesses and unmapped reads are each followed by a readback that shows nothing changed.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int MAX_CPUS  = 4;
  localparam int MASK_BASE = 0;
  localparam int PEND_BASE = 4;
  localparam int RAW_INDEX = 8;
  localparam int FULL_SIZE = 8;
  localparam int STRIDE_SH = 6;
endpackage

// File: rtl/irq_req_vec.sv
module irq_req_vec #(
  parameter int LINES  = 64,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic              ev_assert,
  input  logic [LINE_W-1:0] ev_line,
  output logic [LINES-1:0]  raw_o,
  output logic              spur_o
);
  logic [LINES-1:0] raw_q, raw_d;
  logic             spur_q, spur_d;

  always_comb begin
    raw_d  = raw_q;
    spur_d = 1'b0;
    if (ev_valid) begin
      if (ev_assert) begin
        raw_d[ev_line] = 1'b1;
      end else if (!raw_q[ev_line]) begin
        spur_d = 1'b1;
      end else begin
        raw_d[ev_line] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      spur_q <= 1'b0;
    end else begin
      if (ev_valid) raw_q <= raw_d;
      spur_q <= spur_d;
    end
  end

  assign raw_o  = raw_q;
  assign spur_o = spur_q;

  // R5: an assert event leaves its line set
  p_assert_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_assert) |=> raw_q[$past(ev_line)]);
  // R6: deasserting a clear line only flags
  p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_assert && !raw_q[ev_line]) |=> (spur_q && $stable(raw_q)));
  // R6: a real deassert clears the line without a flag
  p_deassert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_assert && raw_q[ev_line]) |=> (!spur_q && !raw_q[$past(ev_line)]));
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [LINES-1:0] wdata,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] pend_o,
  output logic             irq_o
);
  logic [LINES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  assign mask_o = mask_q;
  assign pend_o = mask_q & raw_i;
  assign irq_o  = |pend_o;

  // R3: a mask write takes the written value
  p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata)));
  // R4: a mask write enabling an active line raises the interrupt
  p_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && |(wdata & raw_i) && $stable(raw_i)) |=> irq_o);
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int LINES   = 64,
  parameter int ADDR_W  = 12,
  localparam int IDX_W  = ADDR_W - STRIDE_SH
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [3:0]                    size_i,
  input  logic [NUM_CPU-1:0][LINES-1:0] mask_i,
  input  logic [NUM_CPU-1:0][LINES-1:0] pend_i,
  input  logic [LINES-1:0]              raw_i,
  output logic [NUM_CPU-1:0]            mask_we_o,
  output logic [LINES-1:0]              rdata_o,
  output logic                          err_o
);
  logic [IDX_W-1:0] idx;
  logic             size_ok, hit;
  logic [LINES-1:0] rdata_d, rdata_q;
  logic             err_d, err_q;

  assign idx     = addr_i[ADDR_W-1:STRIDE_SH];
  assign size_ok = (size_i == 4'(FULL_SIZE));

  always_comb begin
    mask_we_o = '0;
    rdata_d   = '0;
    err_d     = 1'b0;
    hit       = 1'b0;
    if ((wr_i || rd_i) && !size_ok) begin
      err_d = 1'b1;
    end else if (wr_i || rd_i) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (idx == IDX_W'(MASK_BASE + c)) begin
          hit          = 1'b1;
          mask_we_o[c] = wr_i;
          if (rd_i) rdata_d = mask_i[c];
        end
        if (idx == IDX_W'(PEND_BASE + c)) begin
          hit = 1'b1;
          if (wr_i) err_d = 1'b1;
          if (rd_i) rdata_d = pend_i[c];
        end
      end
      if (idx == IDX_W'(RAW_INDEX)) begin
        hit = 1'b1;
        if (wr_i) err_d = 1'b1;
        if (rd_i) rdata_d = raw_i;
      end
      if (!hit) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rdata_d;
      err_q <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R8: a write to a read-only index flags an error
  p_ro_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && size_ok && idx >= IDX_W'(PEND_BASE) && idx <= IDX_W'(RAW_INDEX)) |=> err_o);
  // R9: a wrong-size access flags an error and changes no mask
  p_bad_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_i || rd_i) && !size_ok) |=> (err_o && $stable(mask_i)));
  // R10: read data holds between reads
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int LINES   = 64,
  parameter int ADDR_W  = 12,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [3:0]         reg_size,
  input  logic [LINES-1:0]   reg_wdata,
  output logic [LINES-1:0]   reg_rdata,
  output logic               reg_err,
  input  logic               dev_valid,
  input  logic               dev_assert,
  input  logic [LINE_W-1:0]  dev_line,
  output logic               dev_spurious,
  output logic [LINES-1:0]   raw_req_o,
  output logic [NUM_CPU-1:0] irq_o
);
  logic [LINES-1:0]              raw;
  logic [NUM_CPU-1:0][LINES-1:0] mask, pend;
  logic [NUM_CPU-1:0]            mask_we;

  irq_req_vec #(.LINES(LINES), .LINE_W(LINE_W)) u_req (
    .clk(clk), .rst_n(rst_n), .ev_valid(dev_valid), .ev_assert(dev_assert),
    .ev_line(dev_line), .raw_o(raw), .spur_o(dev_spurious)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_slice #(.LINES(LINES)) u_slice (
      .clk(clk), .rst_n(rst_n), .mask_we(mask_we[c]), .wdata(reg_wdata),
      .raw_i(raw), .mask_o(mask[c]), .pend_o(pend[c]), .irq_o(irq_o[c])
    );
  end

  irq_reg_decode #(.NUM_CPU(NUM_CPU), .LINES(LINES), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .size_i(reg_size), .mask_i(mask), .pend_i(pend), .raw_i(raw),
    .mask_we_o(mask_we), .rdata_o(reg_rdata), .err_o(reg_err)
  );

  assign raw_req_o = raw;

  initial begin
    p_cpu_count_r1: assert (NUM_CPU >= 1 && NUM_CPU <= MAX_CPUS);
  end

  // R6: a real deassert withdraws the line from every processor
  p_withdraw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_assert && !reg_wr) |=> (raw_req_o[$past(dev_line)] == 1'b0));
  // R4: with no active lines no processor is interrupted
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_req_o == '0) |-> (irq_o == '0));
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NV = 15;
  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 line assert, 2 line deassert, 3 read
    logic [11:0] addr;
    logic [63:0] data;
    logic [3:0]  irq;
    logic [63:0] rdata;
    logic [63:0] raw;
  } vec_t;

  localparam logic [63:0] TOP = 64'h8000_0000_0000_0000;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'h000, 64'h5,  4'h0, 64'h0, 64'h0},       // R3 mask0 = lines 0,2
    '{2'd1, 12'h000, 64'd2,  4'h1, 64'h0, 64'h4},       // R5 line 2 to cpu0
    '{2'd0, 12'h040, 64'h4,  4'h3, 64'h0, 64'h4},       // R4 mask1 enables active line
    '{2'd3, 12'h100, 64'h0,  4'h3, 64'h4, 64'h4},       // R2 pending0
    '{2'd3, 12'h200, 64'h0,  4'h3, 64'h4, 64'h4},       // R7 raw at index 8
    '{2'd0, 12'h000, 64'h1,  4'h2, 64'h0, 64'h4},       // R4 mask rewrite withdraws
    '{2'd1, 12'h000, 64'd63, 4'h2, 64'h0, TOP | 64'h4}, // R5 top line, no mask
    '{2'd0, 12'h0C0, TOP,    4'hA, 64'h0, TOP | 64'h4}, // R4 mask3 top line
    '{2'd3, 12'h1C0, 64'h0,  4'hA, TOP,   TOP | 64'h4}, // R2 pending3
    '{2'd2, 12'h000, 64'd2,  4'h8, 64'h0, TOP},         // R6 deassert withdraws cpu1
    '{2'd3, 12'h040, 64'h0,  4'h8, 64'h4, TOP},         // R3 mask1 readback
    '{2'd0, 12'h080, '1,     4'hC, 64'h0, TOP},         // R4 full mask on cpu2
    '{2'd3, 12'h180, 64'h0,  4'hC, TOP,   TOP},         // R2 pending2
    '{2'd2, 12'h000, 64'd63, 4'h0, 64'h0, 64'h0},       // R6 last line cleared
    '{2'd3, 12'h23F, 64'h0,  4'h0, 64'h0, 64'h0}        // R7 low bits ignored
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, reg_err;
  logic [11:0] reg_addr;
  logic [3:0]  reg_size;
  logic [63:0] reg_wdata, reg_rdata, raw_req_o;
  logic        dev_valid, dev_assert, dev_spurious;
  logic [5:0]  dev_line;
  logic [3:0]  irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .dev_valid(dev_valid),
    .dev_assert(dev_assert), .dev_line(dev_line), .dev_spurious(dev_spurious),
    .raw_req_o(raw_req_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_rd = 0; reg_size = 4'd8; reg_addr = '0; reg_wdata = '0;
    dev_valid = 0; dev_assert = 0; dev_line = '0;
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic op(input logic [1:0] kind, input logic [11:0] addr,
                    input logic [63:0] data, input logic [3:0] size);
    @(negedge clk);
    reg_size = size; reg_addr = addr;
    case (kind)
      2'd0: begin reg_wr = 1; reg_wdata = data; end
      2'd1: begin dev_valid = 1; dev_assert = 1; dev_line = data[5:0]; end
      2'd2: begin dev_valid = 1; dev_assert = 0; dev_line = data[5:0]; end
      default: reg_rd = 1;
    endcase
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {60'd0, irq_o}, 64'h0);
    check("R1 raw in reset", raw_req_o, 64'h0);
    check("R1 flags in reset", {62'd0, reg_err, dev_spurious}, 64'h0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op(VECS[i].kind, VECS[i].addr, VECS[i].data, 4'd8);
      check($sformatf("R4 irq step %0d", i), {60'd0, irq_o}, {60'd0, VECS[i].irq});
      check($sformatf("R10 raw step %0d", i), raw_req_o, VECS[i].raw);
      if (VECS[i].kind == 2'd3)
        check($sformatf("R2 rdata step %0d", i), reg_rdata, VECS[i].rdata);
    end

    // R6: deassert of a clear line
    op(2'd2, 12'h0, 64'd5, 4'd8);
    check("R6 spurious flag", {63'd0, dev_spurious}, 64'h1);
    check("R6 spurious raw unchanged", raw_req_o, 64'h0);
    @(negedge clk);
    check("R6 spurious is a pulse", {63'd0, dev_spurious}, 64'h0);
    op(2'd1, 12'h0, 64'd7, 4'd8);
    op(2'd2, 12'h0, 64'd7, 4'd8);
    check("R6 real deassert no flag", {63'd0, dev_spurious}, 64'h0);

    // R8: writes to read-only registers
    op(2'd1, 12'h0, 64'd0, 4'd8);       // raw line 0; mask0 = 1 -> pending0 = 1
    op(2'd0, 12'h100, '1, 4'd8);
    check("R8 pending write error", {63'd0, reg_err}, 64'h1);
    op(2'd3, 12'h100, 64'h0, 4'd8);
    check("R8 pending unchanged", reg_rdata, 64'h1);
    op(2'd0, 12'h200, '1, 4'd8);
    check("R8 raw write error", {63'd0, reg_err}, 64'h1);
    check("R8 raw unchanged", raw_req_o, 64'h1);
    op(2'd3, 12'h280, 64'h0, 4'd8);
    check("R8 unmapped read error", {63'd0, reg_err}, 64'h1);
    check("R8 unmapped read zero", reg_rdata, 64'h0);

    // R9: short access ignored
    op(2'd0, 12'h000, 64'h0, 4'd4);
    check("R9 short write error", {63'd0, reg_err}, 64'h1);
    check("R9 irq kept", {63'd0, irq_o[0]}, 64'h1);
    op(2'd3, 12'h000, 64'h0, 4'd8);
    check("R9 mask0 unchanged", reg_rdata, 64'h1);
    check("R8 error is a pulse", {63'd0, reg_err}, 64'h0);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R1 irq after reset", {60'd0, irq_o}, 64'h0);
    check("R1 raw after reset", raw_req_o, 64'h0);
    rst_n = 1;
    op(2'd3, 12'h080, 64'h0, 4'd8);
    check("R1 mask2 cleared", reg_rdata, 64'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule